// File: doc/BRIEF.md
# Receive Ring Frame Extractor

This block drains frames from a circular receive area inside an on-chip byte RAM. A writer elsewhere deposits each frame as a six-byte header and its payload, then pulses `pkt_add`. The block keeps the count of frames that are waiting. While that count is non-zero it reads the header at its read pointer. The header holds a 16-bit next-frame pointer (bytes 0 and 1), a 16-bit byte length (bytes 2 and 3) and a 16-bit status word (bytes 4 and 5), each stored low byte first. The block then either streams the payload to a consumer over an 8-bit valid/ready interface or discards it.

Once a frame is finished, delivered or not, the block moves its read pointer to the next-frame pointer and retires the frame from the count. It also gives the writer a released-space pointer that never points outside the ring. A discarded frame raises a receiver-hold request and starts a countdown that runs on poll ticks. When the countdown expires, the block pulses a receiver re-enable.

The RAM read port has one cycle of latency. A small skid stage lets payload reads be issued back to back, so a consumer that is always ready receives one byte per cycle.

Top module: `rx_ring_extract`

## Requirements
- R1: After reset, `out_valid`, `ram_rd_en`, `pkt_cnt`, `rd_ptr` and `rx_hold` are all zero, `rx_reenable` is low, and `rel_ptr` equals the ring end address 0x19FF.
- R2: The header is read at `rd_ptr`: next pointer = byte1:byte0, length = byte3:byte2, status = byte5:byte4. The payload of a delivered frame is emitted in RAM address order starting at the byte after the header, and `out_last` is high on exactly the final byte.
- R3: A frame is delivered only when its length is between 1 and 1518 inclusive, status bit 7 is 1, and the next pointer is below 0x1A00. Any other frame produces no output beat.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. No byte is lost or duplicated under any ready pattern.
- R5: After each frame, delivered or dropped, `rd_ptr` equals that frame's next pointer and `pkt_cnt` drops by one.
- R6: After each frame, `rel_ptr` equals the next pointer minus one. If that value lies outside 0x0000..0x19FF, `rel_ptr` equals 0x19FF instead.
- R7: Each `pkt_add` pulse raises `pkt_cnt` by one. Frames are processed one after another for as long as `pkt_cnt` is non-zero.
- R8: RAM reads wrap from address 0x19FF to 0x0000 for both header and payload bytes.
- R9: A dropped frame, when `rx_hold` is low, sets `rx_hold` and loads a countdown of 1000 polls. Each `poll_tick` while `rx_hold` is set decrements the countdown. The poll that finds it at zero clears `rx_hold` and pulses `rx_reenable` for one cycle, which is the 1001st poll after the load.
- R10: A dropped frame while `rx_hold` is already set does not reload the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_add | input | 1 | Writer pulse: one more frame is waiting in the ring |
| poll_tick | input | 1 | Poll strobe that advances the receiver-hold countdown |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_addr | output | 13 | RAM read address |
| ram_rd_data | input | 8 | RAM read data, valid one cycle after the strobe |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Marks the final payload byte of a frame |
| rd_ptr | output | 16 | Current read pointer (start of the next header) |
| rel_ptr | output | 16 | Released-space pointer handed to the writer |
| pkt_cnt | output | 8 | Number of frames waiting |
| rx_hold | output | 1 | Receiver-hold request raised by a dropped frame |
| rx_reenable | output | 1 | One-cycle pulse when the hold countdown expires |

## Verification
The first frames go out under three consumer patterns: always ready, ready every other cycle, and ready two cycles in three. These show whether the skid path loses, repeats or reorders bytes and whether `out_last` stays attached to the right byte. A 1518-byte frame marks the top edge of the length check. Frames placed across the ring end, together with a next pointer of zero, separate correct address wrap from plain increment and show the clamp on the released pointer. A single queue then mixes a good frame with frames that fail the status bit, the 1519-byte limit, the zero-length rule and the next-pointer bound, so each drop cause is seen on its own. Finally two drops about 600 polls apart show whether the countdown is reloaded by the second drop.

// File: rtl/rre_pkg.sv
package rre_pkg;
    localparam int PTR_W     = 16;
    localparam int HDR_BYTES = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_EVAL,
        ST_PAY,
        ST_FIN
    } rre_state_e;

    typedef struct packed {
        logic [PTR_W-1:0] status;
        logic [PTR_W-1:0] len;
        logic [PTR_W-1:0] nxt;
    } rre_hdr_t;
endpackage

// File: rtl/rre_hdr_check.sv
module rre_hdr_check
    import rre_pkg::*;
#(
    parameter logic [PTR_W-1:0] MAX_LEN  = 16'd1518,
    parameter logic [PTR_W-1:0] TX_START = 16'h1A00
) (
    input  logic [HDR_BYTES-1:0][7:0] raw,
    output rre_hdr_t                  hdr,
    output logic                      deliver
);
    // header fields are stored low byte first
    always_comb begin
        hdr.nxt    = {raw[1], raw[0]};
        hdr.len    = {raw[3], raw[2]};
        hdr.status = {raw[5], raw[4]};
    end

    // accept only a non-empty, bounded frame marked good whose successor stays in the ring
    always_comb begin
        deliver = (hdr.len != '0) && (hdr.len <= MAX_LEN) &&
                  hdr.status[7] && (hdr.nxt < TX_START);
    end

    logic unused_status;
    assign unused_status = ^{hdr.status[15:8], hdr.status[6:0]};
endmodule

// File: rtl/rre_rel_calc.sv
module rre_rel_calc
    import rre_pkg::*;
#(
    parameter logic [PTR_W-1:0] RING_START = 16'h0000,
    parameter logic [PTR_W-1:0] RING_END   = 16'h19FF
) (
    input  logic [PTR_W-1:0] nxt,
    output logic [PTR_W-1:0] rel
);
    localparam logic [PTR_W-1:0] SPAN = RING_END - RING_START;

    logic [PTR_W-1:0] minus_one_d;
    logic [PTR_W-1:0] offset_d;

    // one unsigned range test covers both "below start" (after wrap) and "above end"
    always_comb begin
        minus_one_d = nxt - 16'd1;
        offset_d    = minus_one_d - RING_START;
        rel         = (offset_d > SPAN) ? RING_END : minus_one_d;
    end
endmodule

// File: rtl/rre_rx_watchdog.sv
module rre_rx_watchdog #(
    parameter int POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic poll,
    output logic hold,
    output logic reen
);
    localparam int CW = $clog2(POLLS + 1);

    typedef struct packed {
        logic          hold;
        logic [CW-1:0] cnt;
        logic          reen;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d      = wd_q;
        wd_d.reen = 1'b0;
        if (drop && !wd_q.hold) begin
            wd_d.hold = 1'b1;
            wd_d.cnt  = CW'(POLLS);
        end else if (poll && wd_q.hold) begin
            if (wd_q.cnt != '0) begin
                wd_d.cnt = wd_q.cnt - 1'b1;
            end else begin
                wd_d.hold = 1'b0;
                wd_d.reen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign hold = wd_q.hold;
    assign reen = wd_q.reen;

    AST_REEN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reen |-> ($past(hold) && !hold)); // R9

    AST_HOLD_RELOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold) && !$past(poll)) |-> $stable(wd_q.cnt)); // R10
endmodule

// File: rtl/rx_ring_extract.sv
module rx_ring_extract
    import rre_pkg::*;
#(
    parameter int               ADDR_W     = 13,
    parameter int               CNT_W      = 8,
    parameter logic [PTR_W-1:0] RING_START = 16'h0000,
    parameter logic [PTR_W-1:0] RING_END   = 16'h19FF,
    parameter logic [PTR_W-1:0] TX_START   = 16'h1A00,
    parameter logic [PTR_W-1:0] MAX_LEN    = 16'd1518,
    parameter int               WD_POLLS   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_add,
    input  logic              poll_tick,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_rd_addr,
    input  logic [7:0]        ram_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [PTR_W-1:0]  rel_ptr,
    output logic [CNT_W-1:0]  pkt_cnt,
    output logic              rx_hold,
    output logic              rx_reenable
);
    localparam int HC_W = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        rre_state_e                 st;
        logic [ADDR_W-1:0]          addr;
        logic [HC_W-1:0]            issued;
        logic [HC_W-1:0]            got;
        logic [HDR_BYTES-1:0][7:0]  hdr;
        logic [PTR_W-1:0]           remain;
        logic                       infl;
        logic                       infl_last;
        logic                       out_v;
        logic [7:0]                 out_d;
        logic                       out_l;
        logic                       skid_v;
        logic [7:0]                 skid_d;
        logic                       skid_l;
        logic [PTR_W-1:0]           rd_ptr;
        logic [PTR_W-1:0]           rel_ptr;
        logic [CNT_W-1:0]           pkt_cnt;
    } ctl_t;

    ctl_t r_d, r_q;

    rre_hdr_t         hdr_f;
    logic             deliver;
    logic [PTR_W-1:0] rel_val;
    logic             drop_d;
    logic             rd_en_d;
    logic             retire_d;
    logic             fire;
    logic [1:0]       occ;
    logic [1:0]       occ_after;

    function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a);
        if (a == RING_END[ADDR_W-1:0]) begin
            return RING_START[ADDR_W-1:0];
        end
        return a + 1'b1;
    endfunction

    rre_hdr_check #(
        .MAX_LEN  (MAX_LEN),
        .TX_START (TX_START)
    ) u_chk (
        .raw     (r_q.hdr),
        .hdr     (hdr_f),
        .deliver (deliver)
    );

    rre_rel_calc #(
        .RING_START (RING_START),
        .RING_END   (RING_END)
    ) u_rel (
        .nxt (hdr_f.nxt),
        .rel (rel_val)
    );

    rre_rx_watchdog #(
        .POLLS (WD_POLLS)
    ) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .drop  (drop_d),
        .poll  (poll_tick),
        .hold  (rx_hold),
        .reen  (rx_reenable)
    );

    always_comb begin
        r_d          = r_q;
        rd_en_d      = 1'b0;
        drop_d       = 1'b0;
        retire_d     = 1'b0;
        r_d.infl_last = 1'b0;
        fire         = r_q.out_v && out_ready;
        occ          = 2'(r_q.out_v) + 2'(r_q.skid_v) + 2'(r_q.infl);
        occ_after    = occ - 2'(fire);

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.pkt_cnt != '0) begin
                    r_d.st     = ST_HDR;
                    r_d.addr   = r_q.rd_ptr[ADDR_W-1:0];
                    r_d.issued = '0;
                    r_d.got    = '0;
                end
            end
            ST_HDR: begin
                // header reads issue back to back; bytes land one cycle later
                if (r_q.issued != HC_W'(HDR_BYTES)) begin
                    rd_en_d    = 1'b1;
                    r_d.addr   = wrap_inc(r_q.addr);
                    r_d.issued = r_q.issued + 1'b1;
                end
                if (r_q.infl) begin
                    r_d.hdr[r_q.got] = ram_rd_data;
                    r_d.got          = r_q.got + 1'b1;
                    if (r_q.got == HC_W'(HDR_BYTES - 1)) begin
                        r_d.st = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (deliver) begin
                    r_d.remain = hdr_f.len;
                    r_d.st     = ST_PAY;
                end else begin
                    drop_d = 1'b1;
                    r_d.st = ST_FIN;
                end
            end
            ST_PAY: begin
                // keep at most two bytes owned: output, skid and in-flight together
                if ((r_q.remain != '0) && (occ_after < 2'd2)) begin
                    rd_en_d       = 1'b1;
                    r_d.addr      = wrap_inc(r_q.addr);
                    r_d.remain    = r_q.remain - 1'b1;
                    r_d.infl_last = (r_q.remain == 16'd1);
                end
                if (fire || !r_q.out_v) begin
                    if (r_q.skid_v) begin
                        r_d.out_v  = 1'b1;
                        r_d.out_d  = r_q.skid_d;
                        r_d.out_l  = r_q.skid_l;
                        r_d.skid_v = r_q.infl;
                        r_d.skid_d = ram_rd_data;
                        r_d.skid_l = r_q.infl_last;
                    end else begin
                        r_d.out_v = r_q.infl;
                        r_d.out_d = ram_rd_data;
                        r_d.out_l = r_q.infl_last;
                    end
                end else if (r_q.infl) begin
                    r_d.skid_v = 1'b1;
                    r_d.skid_d = ram_rd_data;
                    r_d.skid_l = r_q.infl_last;
                end
                if ((r_q.remain == '0) && !r_q.infl && !r_q.out_v && !r_q.skid_v) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                retire_d    = 1'b1;
                r_d.rd_ptr  = hdr_f.nxt;
                r_d.rel_ptr = rel_val;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.infl    = rd_en_d;
        r_d.pkt_cnt = r_q.pkt_cnt + CNT_W'(pkt_add) - CNT_W'(retire_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.rel_ptr <= RING_END;
        end else begin
            r_q <= r_d;
        end
    end

    assign ram_rd_en   = rd_en_d;
    assign ram_rd_addr = r_q.addr;
    assign out_valid   = r_q.out_v;
    assign out_data    = r_q.out_d;
    assign out_last    = r_q.out_l;
    assign rd_ptr      = r_q.rd_ptr;
    assign rel_ptr     = r_q.rel_ptr;
    assign pkt_cnt     = r_q.pkt_cnt;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R4

    AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.skid_v && r_q.infl) |-> (!r_q.out_v || out_ready)); // R4

    AST_RETIRE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_FIN) && !pkt_add) |=> (pkt_cnt == $past(pkt_cnt) - CNT_W'(1))); // R5

    AST_REL_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ptr >= RING_START) && (rel_ptr <= RING_END)); // R6

    AST_SILENT_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FIN) |-> !out_valid); // R3

    AST_WORK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> (pkt_cnt != '0)); // R7
endmodule

// File: tb/sim_rx_ring_extract.sv
module sim_rx_ring_extract;
    localparam int RING_BYTES = 6656;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_add = 1'b0;
    logic        poll_tick = 1'b0;
    logic        ram_rd_en;
    logic [12:0] ram_rd_addr;
    logic [7:0]  ram_rd_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic [15:0] rd_ptr;
    logic [15:0] rel_ptr;
    logic [7:0]  pkt_cnt;
    logic        rx_hold;
    logic        rx_reenable;

    int total = 0;
    int bad = 0;

    logic [7:0] mem [0:RING_BYTES-1];

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
    end

    rx_ring_extract u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_add     (pkt_add),
        .poll_tick   (poll_tick),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_last    (out_last),
        .rd_ptr      (rd_ptr),
        .rel_ptr     (rel_ptr),
        .pkt_cnt     (pkt_cnt),
        .rx_hold     (rx_hold),
        .rx_reenable (rx_reenable)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 29 + i * 7 + (i >> 5));
    endfunction

    function automatic int exp_rel(input int nxt);
        int m = (nxt - 1) & 16'hFFFF;
        return (m > 16'h19FF) ? 16'h19FF : m;
    endfunction

    task automatic wb(input int a, input logic [7:0] d);
        mem[a % RING_BYTES] = d;
    endtask

    task automatic put_frame(input int at, input int len, input int st, input int nxt, input int seed);
        wb(at + 0, 8'(nxt));
        wb(at + 1, 8'(nxt >> 8));
        wb(at + 2, 8'(len));
        wb(at + 3, 8'(len >> 8));
        wb(at + 4, 8'(st));
        wb(at + 5, 8'(st >> 8));
        for (int i = 0; i < len && i < 1600; i++) wb(at + 6 + i, pat(seed, i));
    endtask

    task automatic add_pkt();
        @(negedge clk) pkt_add = 1'b1;
        @(negedge clk) pkt_add = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // consume one frame; mode 0 always ready, 1 every other cycle, 2 two cycles in three
    task automatic recv_frame(input int len, input int seed, input int mode, input string req);
        int got = 0;
        int errs = 0;
        int act_first = 0;
        int exp_first = 0;
        int lasts = 0;
        logic held_v = 1'b0;
        logic [7:0] held_d = 8'h00;
        bit rdy;
        for (int cyc = 0; cyc < 20000 && got < len; cyc++) begin
            @(negedge clk);
            if (held_v && (!out_valid || out_data != held_d)) begin
                if (errs == 0) begin act_first = out_data; exp_first = held_d; end
                errs++;
            end
            rdy = (mode == 0) || (mode == 1 && cyc[0]) || (mode == 2 && (cyc % 3 != 0));
            out_ready = rdy;
            held_v = out_valid && !rdy;
            held_d = out_data;
            if (out_valid && rdy) begin
                if (out_data != pat(seed, got)) begin
                    if (errs == 0) begin act_first = out_data; exp_first = pat(seed, got); end
                    errs++;
                end
                if (out_last) lasts++;
                if (out_last != (got == len - 1)) errs++;
                got++;
            end
        end
        @(negedge clk) out_ready = 1'b0;
        check(got == len, {req, " beat count"}, got, len);
        check(errs == 0, {req, " payload order/hold"}, act_first, exp_first);
        check(lasts == 1, {req, " single last flag"}, lasts, 1);
    endtask

    task automatic wait_idle(output bit saw_valid);
        saw_valid = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (out_valid) saw_valid = 1'b1;
            if (pkt_cnt == 8'd0 && !u0_busy()) break;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic bit u0_busy();
        return ram_rd_en || out_valid;
    endfunction

    task automatic polls(input int n, inout int reen_cnt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) poll_tick = 1'b1;
            @(negedge clk) poll_tick = 1'b0;
            if (rx_reenable) reen_cnt++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(ram_rd_en == 1'b0, "R1 ram_rd_en", ram_rd_en, 0);
        check(pkt_cnt == 8'd0, "R1 pkt_cnt", pkt_cnt, 0);
        check(rd_ptr == 16'h0, "R1 rd_ptr", rd_ptr, 0);
        check(rel_ptr == 16'h19FF, "R1 rel_ptr", rel_ptr, 16'h19FF);
        check(rx_hold == 1'b0 && rx_reenable == 1'b0, "R1 hold/reenable", rx_hold, 0);
    endtask

    task automatic t_single();
        bit sv;
        put_frame(16'h0000, 10, 16'h0080, 16'h0010, 1);
        add_pkt();
        recv_frame(10, 1, 0, "R2 single frame");
        wait_idle(sv);
        check(rd_ptr == 16'h0010, "R5 rd_ptr after single", rd_ptr, 16'h0010);
        check(pkt_cnt == 8'd0, "R5 pkt_cnt after single", pkt_cnt, 0);
        check(rel_ptr == 16'(exp_rel(16'h0010)), "R6 rel_ptr after single", rel_ptr, exp_rel(16'h0010));
        check(rx_hold == 1'b0, "R9 no hold after delivery", rx_hold, 0);
    endtask

    task automatic t_burst();
        bit sv;
        put_frame(16'h0010, 33, 16'h8380, 16'h0040, 2);
        put_frame(16'h0040, 64, 16'h0080, 16'h0090, 3);
        put_frame(16'h0090, 1,  16'h00FF, 16'h00A0, 4);
        add_pkt();
        add_pkt();
        add_pkt();
        check(pkt_cnt == 8'd3, "R7 count after three adds", pkt_cnt, 3);
        recv_frame(33, 2, 1, "R4 burst frame A");
        recv_frame(64, 3, 2, "R4 burst frame B");
        recv_frame(1,  4, 0, "R7 burst frame C");
        wait_idle(sv);
        check(rd_ptr == 16'h00A0, "R5 rd_ptr after burst", rd_ptr, 16'h00A0);
        check(rel_ptr == 16'h009F, "R6 rel_ptr after burst", rel_ptr, 16'h009F);
        check(pkt_cnt == 8'd0, "R7 burst drained", pkt_cnt, 0);
    endtask

    task automatic t_max_len();
        bit sv;
        put_frame(16'h00A0, 1518, 16'h0080, 16'h0694, 5);
        add_pkt();
        recv_frame(1518, 5, 0, "R3 length 1518 delivered");
        wait_idle(sv);
        check(rd_ptr == 16'h0694, "R5 rd_ptr after max frame", rd_ptr, 16'h0694);
    endtask

    task automatic t_wrap();
        bit sv;
        put_frame(16'h0694, 4, 16'h0080, 16'h19F8, 6);
        add_pkt();
        recv_frame(4, 6, 0, "R2 jump frame");
        wait_idle(sv);
        check(rd_ptr == 16'h19F8, "R5 rd_ptr jump", rd_ptr, 16'h19F8);
        put_frame(16'h19F8, 20, 16'h0080, 16'h0012, 7);
        add_pkt();
        recv_frame(20, 7, 2, "R8 payload across ring end");
        wait_idle(sv);
        check(rd_ptr == 16'h0012, "R8 rd_ptr after wrap", rd_ptr, 16'h0012);
        check(rel_ptr == 16'h0011, "R6 rel_ptr after wrap", rel_ptr, 16'h0011);
        put_frame(16'h0012, 2, 16'h0080, 16'h19F0, 8);
        put_frame(16'h19F0, 10, 16'h0080, 16'h0000, 9);
        add_pkt();
        add_pkt();
        recv_frame(2, 8, 0, "R7 frame before ring end");
        recv_frame(10, 9, 1, "R8 frame ending at ring end");
        wait_idle(sv);
        check(rd_ptr == 16'h0000, "R5 rd_ptr wrapped to zero", rd_ptr, 0);
        check(rel_ptr == 16'h19FF, "R6 rel_ptr clamp for next=0", rel_ptr, 16'h19FF);
    endtask

    task automatic t_drops();
        bit sv;
        // frames: bad status, too long, good, zero length, next pointer past ring
        put_frame(16'h0000, 8,    16'h007F, 16'h0020, 10);
        put_frame(16'h0020, 1519, 16'h0080, 16'h0040, 11);
        put_frame(16'h0040, 5,    16'h0080, 16'h0050, 12);
        put_frame(16'h0050, 0,    16'h0080, 16'h0060, 13);
        put_frame(16'h0060, 4,    16'h0080, 16'h1A00, 14);
        for (int i = 0; i < 5; i++) add_pkt();
        recv_frame(5, 12, 0, "R3 only good frame among drops");
        wait_idle(sv);
        check(sv == 1'b0, "R3 no beats from dropped frames", sv, 0);
        check(pkt_cnt == 8'd0, "R5 all five retired", pkt_cnt, 0);
        check(rd_ptr == 16'h1A00, "R5 rd_ptr follows bad next", rd_ptr, 16'h1A00);
        check(rel_ptr == 16'h19FF, "R6 rel_ptr clamp above ring", rel_ptr, 16'h19FF);
        check(rx_hold == 1'b1, "R9 hold raised by drop", rx_hold, 1);
    endtask

    task automatic t_wdog();
        bit sv;
        int reen = 0;
        do_reset();
        check(rx_hold == 1'b0, "R1 hold cleared by reset", rx_hold, 0);
        put_frame(16'h0000, 8, 16'h0000, 16'h0040, 15);
        add_pkt();
        wait_idle(sv);
        check(rx_hold == 1'b1, "R9 hold after first drop", rx_hold, 1);
        polls(600, reen);
        put_frame(16'h0040, 8, 16'h0000, 16'h0080, 16);
        add_pkt();
        wait_idle(sv);
        polls(400, reen);
        check(reen == 0 && rx_hold == 1'b1, "R10 no reload: still held after 1000 polls", reen, 0);
        polls(1, reen);
        check(reen == 1, "R9 reenable on poll 1001", reen, 1);
        check(rx_hold == 1'b0, "R10 hold cleared at expiry", rx_hold, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < RING_BYTES; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst();
        t_max_len();
        t_wrap();
        t_drops();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule